// File: doc/BRIEF.md
# YCbCr 4:2:2 Video Output Core

This core turns a pixel stream pushed by a DMA engine into a parallel video port for an HDMI transmitter chip. The port carries 16-bit YCbCr 4:2:2 words. Horizontal sync, vertical sync and data-enable each have their own pin. Line and frame geometry come from configuration inputs: active size, front porch, sync width and back porch on each axis. Any format fits within the counter width. The core runs on a pixel clock supplied from outside.

A small elastic FIFO sits between the stream and the timing generator. No frame is stored, so the stream must keep pace with the active pixels of every frame. The FIFO is flushed at the start of each vertical sync, which lets every frame begin aligned. The output enable and a debug colour-override enable act only on a rising edge of their control bit. When the FIFO runs dry, a sticky underflow flag is raised and black is sent in place of the missing pixel.

Top module: `yc422_video_out`

## Requirements
- R1: While reset is high, vid_de is 0, vid_data is 0x1080, s_ready is 1, uf_flag is 0, and each sync pin sits at its inactive level. A sync pin's inactive level is the inverse of its polarity input.
- R2: While output is running, vid_de is high for exactly cfg_h_act consecutive cycles on each active line, and each frame has cfg_v_act such lines.
- R3: Each line is active, then front porch, then sync, then back porch. The hsync pulse lasts cfg_h_sync cycles and starts cfg_h_fp cycles after vid_de falls. The vsync pulse lasts cfg_v_sync whole lines.
- R4: A sync pin is active high when its polarity input (cfg_hs_pol, cfg_vs_pol) is 1 and active low when it is 0. Pulse widths do not change with polarity.
- R5: s_data is {Y[23:16], Cb[15:8], Cr[7:0]}. Each vid_data word is {Y, C}: Y in bits [15:8] and C in bits [7:0]. C is Cb on even columns and Cr on odd columns, where column 0 is the first active pixel of the line. Pixels appear in the order they were pushed.
- R6: Whenever vid_de is low, vid_data is black, 0x1080.
- R7: Output starts only after ctl_out_en goes from 0 to 1. A bit already high when reset ends does nothing. After the edge, vid_de stays low until the next vertical-sync start; the next active region is the first one output. While ctl_out_en is 0, vid_de stays low.
- R8: A 0-to-1 edge of ctl_pat_en turns on the colour override, and it stays on while the bit is held. During the override, active words are {pat_y, pat_cb} on even columns and {pat_y, pat_cr} on odd columns. The FIFO is not read during the override, and the underflow flag is not raised.
- R9: If the FIFO is empty when an active pixel is due, that word is 0x1080 with vid_de high, and uf_flag goes to 1 and stays there. A one-cycle pulse on uf_clr clears it. A new underflow in the same cycle takes priority over the clear.
- R10: At the start of every vertical sync, all entries left in the FIFO are discarded.
- R11: s_ready is low exactly when the FIFO holds 2**FIFO_AW entries. A push offered while the FIFO is full is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| s_valid | input | 1 | Stream pixel offered |
| s_data | input | 24 | Stream pixel {Y, Cb, Cr} |
| s_ready | output | 1 | FIFO can accept a pixel |
| cfg_h_act | input | CW | Active pixels per line |
| cfg_h_fp | input | CW | Horizontal front porch, in cycles |
| cfg_h_sync | input | CW | Hsync width, in cycles |
| cfg_h_bp | input | CW | Horizontal back porch, in cycles |
| cfg_v_act | input | CW | Active lines per frame |
| cfg_v_fp | input | CW | Vertical front porch, in lines |
| cfg_v_sync | input | CW | Vsync width, in lines |
| cfg_v_bp | input | CW | Vertical back porch, in lines |
| cfg_hs_pol | input | 1 | 1 = hsync active high |
| cfg_vs_pol | input | 1 | 1 = vsync active high |
| ctl_out_en | input | 1 | Output enable (acts on a rising edge) |
| ctl_pat_en | input | 1 | Colour override enable (acts on a rising edge) |
| pat_y | input | 8 | Override luma |
| pat_cb | input | 8 | Override blue chroma |
| pat_cr | input | 8 | Override red chroma |
| uf_clr | input | 1 | Clear pulse for the underflow flag |
| uf_flag | output | 1 | Sticky underflow flag |
| vid_data | output | 16 | 4:2:2 word {Y, C} |
| vid_hs | output | 1 | Horizontal sync |
| vid_vs | output | 1 | Vertical sync |
| vid_de | output | 1 | Data enable |

## Verification
A wrong horizontal or vertical counter shows up at the pins within one line or one frame. It appears as a data-enable run of the wrong length, a sync pulse of the wrong width, or a front porch of the wrong length. A FIFO pointer that slips, or a flush that is skipped, changes the pixel sequence. The first active word of the next frame then carries a leftover or shifted pixel. A broken edge detector or a broken sticky flag shows up as data-enable inside a frame that should stay dark, or as a flag level that is wrong a few cycles after the frame or the clear pulse.

// File: rtl/yc_vid_pkg.sv
package yc_vid_pkg;

    typedef struct packed {
        logic [7:0] y;
        logic [7:0] cb;
        logic [7:0] cr;
    } pix_t;

    typedef struct packed {
        logic [7:0] y;
        logic [7:0] c;
    } word_t;

    typedef struct packed {
        logic active;
        logic hsync;
        logic vsync;
        logic odd;
        logic frame_tick;
    } tpos_t;

    localparam word_t BLACK_WORD = '{y: 8'h10, c: 8'h80};

    function automatic word_t pack422(input pix_t p, input logic odd);
        word_t w;
        w.y = p.y;
        w.c = odd ? p.cr : p.cb;
        return w;
    endfunction

endpackage

// File: rtl/yc_vid_timing.sv
module yc_vid_timing
    import yc_vid_pkg::*;
#(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] h_act,
    input  logic [CW-1:0] h_fp,
    input  logic [CW-1:0] h_sync,
    input  logic [CW-1:0] h_bp,
    input  logic [CW-1:0] v_act,
    input  logic [CW-1:0] v_fp,
    input  logic [CW-1:0] v_sync,
    input  logic [CW-1:0] v_bp,
    output tpos_t         pos
);
    localparam int SW = CW + 2;

    logic [SW-1:0] h_cnt, v_cnt;
    logic [SW-1:0] hs_beg, hs_end, h_last;
    logic [SW-1:0] vs_beg, vs_end, v_last;

    always_comb begin
        hs_beg = SW'(h_act) + SW'(h_fp);
        hs_end = hs_beg + SW'(h_sync);
        h_last = hs_end + SW'(h_bp) - SW'(1);
        vs_beg = SW'(v_act) + SW'(v_fp);
        vs_end = vs_beg + SW'(v_sync);
        v_last = vs_end + SW'(v_bp) - SW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            h_cnt <= '0;
            v_cnt <= '0;
        end else if (h_cnt >= h_last) begin
            h_cnt <= '0;
            v_cnt <= (v_cnt >= v_last) ? '0 : v_cnt + SW'(1);
        end else begin
            h_cnt <= h_cnt + SW'(1);
        end
    end

    always_comb begin
        pos.active     = (h_cnt < SW'(h_act)) && (v_cnt < SW'(v_act));
        pos.hsync      = (h_cnt >= hs_beg) && (h_cnt < hs_end);
        pos.vsync      = (v_cnt >= vs_beg) && (v_cnt < vs_end);
        pos.odd        = h_cnt[0];
        pos.frame_tick = (h_cnt == '0) && (v_cnt == vs_beg);
    end

endmodule

// File: rtl/yc_vid_fifo.sv
module yc_vid_fifo #(
    parameter int DW = 24,
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    output logic          full,
    output logic          empty,
    output logic [AW:0]   count
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          wr_ok, rd_ok;

    assign full    = (count == (AW+1)'(DEPTH));
    assign empty   = (count == '0);
    assign wr_ok   = wr_en && !full;
    assign rd_ok   = rd_en && !empty;
    assign rd_data = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (wr_ok) mem[wr_ptr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (wr_ok) wr_ptr <= wr_ptr + AW'(1);
            if (rd_ok) rd_ptr <= rd_ptr + AW'(1);
            case ({wr_ok, rd_ok})
                2'b10:   count <= count + (AW+1)'(1);
                2'b01:   count <= count - (AW+1)'(1);
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/yc_vid_ctrl.sv
module yc_vid_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic out_en_bit,
    input  logic pat_en_bit,
    input  logic frame_tick,
    input  logic uf_evt,
    input  logic uf_clr,
    output logic running,
    output logic pat_on,
    output logic uf_flag
);
    logic out_q, pat_q, armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q   <= 1'b1;
            pat_q   <= 1'b1;
            armed   <= 1'b0;
            running <= 1'b0;
            pat_on  <= 1'b0;
            uf_flag <= 1'b0;
        end else begin
            out_q <= out_en_bit;
            pat_q <= pat_en_bit;

            if (!out_en_bit) begin
                armed   <= 1'b0;
                running <= 1'b0;
            end else begin
                if (!out_q) armed <= 1'b1;
                if (frame_tick && armed) begin
                    running <= 1'b1;
                    armed   <= 1'b0;
                end
            end

            if (!pat_en_bit)  pat_on <= 1'b0;
            else if (!pat_q)  pat_on <= 1'b1;

            if (uf_evt)       uf_flag <= 1'b1;
            else if (uf_clr)  uf_flag <= 1'b0;
        end
    end

endmodule

// File: rtl/yc422_video_out.sv
module yc422_video_out
    import yc_vid_pkg::*;
#(
    parameter int CW      = 12,
    parameter int FIFO_AW = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          s_valid,
    input  logic [23:0]   s_data,
    output logic          s_ready,
    input  logic [CW-1:0] cfg_h_act,
    input  logic [CW-1:0] cfg_h_fp,
    input  logic [CW-1:0] cfg_h_sync,
    input  logic [CW-1:0] cfg_h_bp,
    input  logic [CW-1:0] cfg_v_act,
    input  logic [CW-1:0] cfg_v_fp,
    input  logic [CW-1:0] cfg_v_sync,
    input  logic [CW-1:0] cfg_v_bp,
    input  logic          cfg_hs_pol,
    input  logic          cfg_vs_pol,
    input  logic          ctl_out_en,
    input  logic          ctl_pat_en,
    input  logic [7:0]    pat_y,
    input  logic [7:0]    pat_cb,
    input  logic [7:0]    pat_cr,
    input  logic          uf_clr,
    output logic          uf_flag,
    output logic [15:0]   vid_data,
    output logic          vid_hs,
    output logic          vid_vs,
    output logic          vid_de
);
    tpos_t            pos;
    logic             running, pat_on;
    logic             pix_due, fifo_rd, fifo_full, fifo_empty, uf_evt, flush;
    logic [23:0]      fifo_q;
    logic [FIFO_AW:0] fifo_cnt;
    pix_t             pat_pix;
    word_t            nxt_word;

    yc_vid_timing #(.CW(CW)) u_timing (
        .clk(clk), .rst(rst),
        .h_act(cfg_h_act), .h_fp(cfg_h_fp), .h_sync(cfg_h_sync), .h_bp(cfg_h_bp),
        .v_act(cfg_v_act), .v_fp(cfg_v_fp), .v_sync(cfg_v_sync), .v_bp(cfg_v_bp),
        .pos(pos)
    );

    assign flush   = pos.frame_tick;
    assign pix_due = running && pos.active;
    assign fifo_rd = pix_due && !pat_on && !fifo_empty;
    assign uf_evt  = pix_due && !pat_on && fifo_empty;
    assign s_ready = !fifo_full;

    yc_vid_fifo #(.DW(24), .AW(FIFO_AW)) u_fifo (
        .clk(clk), .rst(rst), .flush(flush),
        .wr_en(s_valid), .wr_data(s_data),
        .rd_en(fifo_rd), .rd_data(fifo_q),
        .full(fifo_full), .empty(fifo_empty), .count(fifo_cnt)
    );

    yc_vid_ctrl u_ctrl (
        .clk(clk), .rst(rst),
        .out_en_bit(ctl_out_en), .pat_en_bit(ctl_pat_en),
        .frame_tick(pos.frame_tick), .uf_evt(uf_evt), .uf_clr(uf_clr),
        .running(running), .pat_on(pat_on), .uf_flag(uf_flag)
    );

    always_comb begin
        pat_pix = '{y: pat_y, cb: pat_cb, cr: pat_cr};
        if (!pix_due)        nxt_word = BLACK_WORD;
        else if (pat_on)     nxt_word = pack422(pat_pix, pos.odd);
        else if (fifo_empty) nxt_word = BLACK_WORD;
        else                 nxt_word = pack422(pix_t'(fifo_q), pos.odd);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vid_data <= BLACK_WORD;
            vid_de   <= 1'b0;
            vid_hs   <= !cfg_hs_pol;
            vid_vs   <= !cfg_vs_pol;
        end else begin
            vid_data <= nxt_word;
            vid_de   <= pix_due;
            vid_hs   <= pos.hsync ~^ cfg_hs_pol;
            vid_vs   <= pos.vsync ~^ cfg_vs_pol;
        end
    end

endmodule

// File: rtl/yc422_video_out_chk.sv
module yc422_video_out_chk #(
    parameter int FIFO_AW = 10
) (
    input logic             clk,
    input logic             rst,
    input logic             vid_de,
    input logic [15:0]      vid_data,
    input logic             ctl_out_en,
    input logic             uf_flag,
    input logic             uf_clr,
    input logic [FIFO_AW:0] fifo_cnt,
    input logic             flush,
    input logic             fifo_rd,
    input logic             pat_on
);
    localparam int DEPTH = 1 << FIFO_AW;

    AST_BLANK_BLACK: assert property (@(posedge clk) disable iff (rst)
        !vid_de |-> vid_data == 16'h1080); // R6

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        fifo_cnt <= (FIFO_AW+1)'(DEPTH)); // R11

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        flush |=> fifo_cnt == '0); // R10

    AST_UF_STICKY: assert property (@(posedge clk) disable iff (rst)
        (uf_flag && !uf_clr) |=> uf_flag); // R9

    AST_PAT_NO_POP: assert property (@(posedge clk) disable iff (rst)
        pat_on |-> !fifo_rd); // R8

    AST_DE_OFF_DISABLED: assert property (@(posedge clk) disable iff (rst)
        (!ctl_out_en && $past(!ctl_out_en)) |=> !vid_de); // R7

endmodule

bind yc422_video_out yc422_video_out_chk #(.FIFO_AW(FIFO_AW)) u_chk (
    .clk(clk), .rst(rst), .vid_de(vid_de), .vid_data(vid_data),
    .ctl_out_en(ctl_out_en), .uf_flag(uf_flag), .uf_clr(uf_clr),
    .fifo_cnt(fifo_cnt), .flush(flush), .fifo_rd(fifo_rd), .pat_on(pat_on)
);

// File: tb/yc422_video_out_tb.sv
module yc422_video_out_tb;
    localparam int CLK_PERIOD = 10;
    localparam int CW = 8;
    localparam int FAW = 6;
    localparam int DEPTH = 1 << FAW;
    localparam int H_ACT = 8, H_FP = 2, H_SYNC = 3, H_BP = 3;
    localparam int V_ACT = 4, V_FP = 1, V_SYNC = 2, V_BP = 2;
    localparam int H_TOT = H_ACT + H_FP + H_SYNC + H_BP;

    logic clk = 0, rst = 1;
    logic s_valid = 0, s_ready;
    logic [23:0] s_data = '0;
    logic hpol = 1, vpol = 1;
    logic out_en = 1, pat_en = 0, uf_clr = 0, uf_flag;
    logic [7:0] py = 0, pcb = 0, pcr = 0;
    logic [15:0] vid_data;
    logic vid_hs, vid_vs, vid_de;

    int n_cmp = 0, n_bad = 0, cyc = 0, mode = 0;
    bit meas_en = 0, done = 0;
    logic [23:0] exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    yc422_video_out #(.CW(CW), .FIFO_AW(FAW)) u_dut (
        .clk(clk), .rst(rst), .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready),
        .cfg_h_act(CW'(H_ACT)), .cfg_h_fp(CW'(H_FP)), .cfg_h_sync(CW'(H_SYNC)), .cfg_h_bp(CW'(H_BP)),
        .cfg_v_act(CW'(V_ACT)), .cfg_v_fp(CW'(V_FP)), .cfg_v_sync(CW'(V_SYNC)), .cfg_v_bp(CW'(V_BP)),
        .cfg_hs_pol(hpol), .cfg_vs_pol(vpol), .ctl_out_en(out_en), .ctl_pat_en(pat_en),
        .pat_y(py), .pat_cb(pcb), .pat_cr(pcr), .uf_clr(uf_clr), .uf_flag(uf_flag),
        .vid_data(vid_data), .vid_hs(vid_hs), .vid_vs(vid_vs), .vid_de(vid_de)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_word(input logic [23:0] p, input int col);
        return {p[23:16], (col % 2 == 1) ? p[7:0] : p[15:8]};
    endfunction

    // port monitor: line/sync geometry and per-pixel data
    int de_run = 0, col = 0, gap = 0, hs_w = 0, vs_w = 0, lines = 0;
    bit de_p = 0, hs_p = 0, vs_p = 0, gap_ok = 0, hs_on = 0, vs_on = 0;
    always @(negedge clk) begin
        logic hs_a, vs_a;
        logic [23:0] p;
        hs_a = (vid_hs == hpol);
        vs_a = (vid_vs == vpol);
        if (rst || !meas_en) begin
            gap_ok = 0; hs_on = 0; vs_on = 0; lines = 0; de_run = 0; col = 0;
        end else begin
            if (hs_a && !hs_p) begin
                if (gap_ok) chk(gap == H_FP, "R3 front porch", gap, H_FP);
                gap_ok = 0; hs_on = 1; hs_w = 0;
            end
            if (hs_a) hs_w++;
            else if (hs_p && hs_on) chk(hs_w == H_SYNC, hpol ? "R3 hsync width" : "R4 hsync width low", hs_w, H_SYNC);
            if (vs_a && !vs_p) begin
                if (lines != 0) chk(lines == V_ACT, "R2 lines per frame", lines, V_ACT);
                lines = 0; vs_on = 1; vs_w = 0;
            end
            if (vs_a) vs_w++;
            else if (vs_p && vs_on) chk(vs_w == V_SYNC*H_TOT, vpol ? "R3 vsync width" : "R4 vsync width low", vs_w, V_SYNC*H_TOT);
            if (vid_de) begin
                if (!de_p) lines++;
                case (mode)
                    1: if (exp_q.size() == 0) chk(0, "R5 unexpected pixel", vid_data, 0);
                       else begin
                           p = exp_q.pop_front();
                           chk(vid_data == exp_word(p, col), "R5 packing", vid_data, exp_word(p, col));
                       end
                    2: chk(vid_data == {py, (col % 2 == 1) ? pcr : pcb}, "R8 pattern", vid_data, {py, (col % 2 == 1) ? pcr : pcb});
                    3: chk(0, "R7 DE while not running", 1, 0);
                    4: chk(vid_data == 16'h1080, "R9 underflow black", vid_data, 16'h1080);
                    default: ;
                endcase
                col++; de_run++;
            end else begin
                if (de_p) begin
                    chk(de_run == H_ACT, "R2 DE run", de_run, H_ACT);
                    gap = 1; gap_ok = 1;
                end else gap++;
                chk(vid_data == 16'h1080, "R6 blank black", vid_data, 16'h1080);
                col = 0; de_run = 0;
            end
        end
        de_p = vid_de; hs_p = hs_a; vs_p = vs_a;
    end

    task automatic wait_vs();
        bit was;
        was = (vid_vs == vpol);
        forever begin
            @(negedge clk);
            if ((vid_vs == vpol) && !was) break;
            was = (vid_vs == vpol);
        end
    endtask

    task automatic push_frame(input int n, input int nexp);
        for (int i = 0; i < n; i++) begin
            logic [23:0] p;
            p = 24'($urandom);
            if (i < nexp) exp_q.push_back(p);
            s_valid = 1; s_data = p;
            @(negedge clk);
        end
        s_valid = 0;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 60000 && !done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=<60000", cyc);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'h5EED);
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(vid_de == 0, "R1 de", vid_de, 0);
        chk(vid_data == 16'h1080, "R1 data", vid_data, 16'h1080);
        chk(s_ready == 1, "R1 ready", s_ready, 1);
        chk(uf_flag == 0, "R1 uf", uf_flag, 0);
        chk(vid_hs == 0 && vid_vs == 0, "R1 syncs idle", {vid_hs, vid_vs}, 0);
        rst = 0; meas_en = 1; mode = 3;
        // R7: held-high enable from reset does nothing
        wait_vs(); wait_vs();
        out_en = 0; repeat (2) @(negedge clk); out_en = 1;
        wait_vs(); mode = 1; push_frame(32, 32);
        repeat (3) begin wait_vs(); push_frame(32, 32); end
        // R10: leftovers discarded at vsync
        wait_vs(); push_frame(40, 32);
        wait_vs(); push_frame(32, 32);
        wait_vs();
        chk(exp_q.size() == 0, "R10 R5 all pixels seen", exp_q.size(), 0);
        // R9 underflow
        mode = 4;
        wait_vs();
        chk(uf_flag == 1, "R9 flag set", uf_flag, 1);
        repeat (3) @(negedge clk);
        chk(uf_flag == 1, "R9 flag sticky", uf_flag, 1);
        uf_clr = 1; @(negedge clk); uf_clr = 0; @(negedge clk);
        chk(uf_flag == 0, "R9 flag cleared", uf_flag, 0);
        // R8 colour override
        py = 8'($urandom); pcb = 8'($urandom); pcr = 8'($urandom);
        mode = 2; pat_en = 1;
        wait_vs();
        chk(uf_flag == 0, "R8 no underflow during override", uf_flag, 0);
        out_en = 0; pat_en = 0; mode = 3;
        // R11 full FIFO
        wait_vs();
        push_frame(DEPTH, 0);
        chk(s_ready == 0, "R11 ready low when full", s_ready, 0);
        push_frame(3, 0);
        chk(s_ready == 0, "R11 extra pushes dropped", s_ready, 0);
        wait_vs();
        chk(s_ready == 1, "R10 flush frees FIFO", s_ready, 1);
        // R4 polarity
        meas_en = 0; hpol = 0; vpol = 0;
        repeat (3) @(negedge clk);
        wait_vs(); meas_en = 1;
        chk(vid_hs == 1, "R4 hsync idle high", vid_hs, 1);
        wait_vs(); wait_vs();
        chk(vid_vs == 0, "R4 vsync active low", vid_vs, 0);
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule